// File: doc/BRIEF.md
# Serial Clock-Calendar Register Front End

This block is the serial slave side of a small clock-calendar register file. It holds sixteen byte-wide registers at addresses 0x0 to 0xF. A host reaches them through a four-wire serial link with an active-high select. The first byte of every transaction is a command that gives a direction and a starting register. The bytes after it are data, and the register pointer steps forward after each data byte, so one transaction can move a whole block of registers. The pointer wraps from 0xF to 0x0.

Counting, alarm comparison and rate trimming sit elsewhere and only read these registers. The block itself owns the control behaviour that those neighbours rely on. It provides the halt control and its run indication, a write pattern that restores every register to its default, and the clock-invalid flag kept in the top bit of the seconds register. The serial pins are sampled with the system clock through synchronisers, so the link clock has to run well below the system clock.

Top module: `rtc_spi_regs`

## Requirements
- R1: After reset, every register reads 0x00 except seconds (address 0x2), which reads 0x80, and `run_o` is high.
- R2: A command byte with bit 4 set and bit 7 clear selects a write. Its bits 3:0 give the first address, and each following complete byte is stored at the current address.
- R3: A command byte with bit 4 and bit 7 both set selects a read. Each following byte shifts out the register at the current address, MSB first. `spi_miso_o` changes after a falling SCLK edge, `spi_mosi_i` is sampled on a rising edge, and `spi_miso_o` is 0 outside read data.
- R4: After each data byte the address steps by one and wraps from 0xF to 0x0. A burst of seven bytes from 0x2 fills seconds, minutes, hours, day, weekday, month and year.
- R5: A command byte with bit 4 clear is ignored: no later byte of that transaction changes any register, and `spi_miso_o` stays 0.
- R6: Bit 5 of address 0x0 is the halt bit. It reads back as written, `run_o` is low while it is 1, and writing 0x00 raises `run_o` again.
- R7: A write to address 0x0 whose data has bits 3, 4 and 6 all set returns every register to its R1 default, address 0x0 included.
- R8: Bit 7 of seconds is set by `osc_fail_i` and stays set until seconds is written. Writing seconds always clears that bit, whatever bit 7 of the written data is.
- R9: Lowering `spi_cs_i` in the middle of a byte discards the partial byte, and the next transaction starts again with a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_i | input | 1 | Select, active high |
| spi_sclk_i | input | 1 | Serial clock, idle low |
| spi_mosi_i | input | 1 | Serial data from host |
| spi_miso_o | output | 1 | Serial data to host |
| osc_fail_i | input | 1 | Oscillator failure pulse from the timebase |
| run_o | output | 1 | Time counters may advance |

## Verification
The bench builds the block with three synchroniser stages instead of the default two, and it holds each SCLK half period for eight system clocks. This exercises the longest pin-to-action latency while a shifted-out bit still settles before the host samples it. With the default 8-bit data and 4-bit address, a burst long enough to pass 0xF is only a few bytes, so wrap-around shows up both in directed bursts and in the random ones. Those random bursts can also write the reset pattern into address 0x0 or set the halt bit.

// File: rtl/rtc_spi_pkg.sv
package rtc_spi_pkg;
    localparam int DATA_W      = 8;
    localparam int ADDR_W      = 4;
    localparam int REG_CNT     = 1 << ADDR_W;
    localparam int CMD_WR_BIT  = 4;
    localparam int CMD_RD_BIT  = 7;
    localparam int HALT_BIT    = 5;
    localparam int INVALID_BIT = 7;
    localparam logic [ADDR_W-1:0] A_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] A_SEC  = 4'h2;
    localparam logic [DATA_W-1:0] CLR_PATTERN = 8'h58;

    typedef enum logic [1:0] {PH_CMD, PH_WRITE, PH_READ, PH_SKIP} phase_t;

    typedef logic [REG_CNT-1:0][DATA_W-1:0] regfile_t;

    function automatic regfile_t regfile_default();
        regfile_t r;
        r = '0;
        r[A_SEC][INVALID_BIT] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/rtc_spi_link.sv
module rtc_spi_link #(
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              sclk_i,
    input  logic              mosi_i,
    input  logic [DATA_W-1:0] tx_byte_i,
    output logic              cs_o,
    output logic              byte_stb_o,
    output logic [DATA_W-1:0] byte_o,
    output logic              load_stb_o,
    output logic              miso_o
);
    localparam int CNT_W = $clog2(DATA_W);

    logic [2:0] stg_q [SYNC_STAGES];

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
                if (!rst_n) stg_q[g] <= '0;
                else        stg_q[g] <= {cs_i, sclk_i, mosi_i};
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
                if (!rst_n) stg_q[g] <= '0;
                else        stg_q[g] <= stg_q[g-1];
        end
    end

    logic cs_s, sclk_s, mosi_s;
    assign {cs_s, sclk_s, mosi_s} = stg_q[SYNC_STAGES-1];

    typedef struct packed {
        logic              sclk_prev;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] rx;
        logic [DATA_W-1:0] tx;
    } link_t;

    link_t st_d, st_q;
    logic  rise, fall;

    always_comb begin
        st_d = st_q;
        rise = cs_s && sclk_s && !st_q.sclk_prev;
        fall = cs_s && !sclk_s && st_q.sclk_prev;
        st_d.sclk_prev = sclk_s;
        if (!cs_s) begin
            st_d.cnt = '0;
            st_d.rx  = '0;
            st_d.tx  = '0;
        end else begin
            if (rise) begin
                st_d.rx  = {st_q.rx[DATA_W-2:0], mosi_s};
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (fall) begin
                if (st_q.cnt == '0) st_d.tx = tx_byte_i;
                else                st_d.tx = {st_q.tx[DATA_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;

    assign cs_o       = cs_s;
    assign byte_stb_o = rise && (st_q.cnt == CNT_W'(DATA_W - 1));
    assign byte_o     = {st_q.rx[DATA_W-2:0], mosi_s};
    assign load_stb_o = fall && (st_q.cnt == '0);
    assign miso_o     = st_q.tx[DATA_W-1];

    // R9: a dropped select leaves no partial byte and a quiet output
    assert_cs_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_s) |=> (st_q.cnt == '0 && !miso_o));
endmodule

// File: rtl/rtc_spi_regs.sv
module rtc_spi_regs
    import rtc_spi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_cs_i,
    input  logic spi_sclk_i,
    input  logic spi_mosi_i,
    output logic spi_miso_o,
    input  logic osc_fail_i,
    output logic run_o
);
    logic              cs_s, byte_stb, load_stb;
    logic [DATA_W-1:0] rx_byte, tx_byte;

    rtc_spi_link #(.SYNC_STAGES(SYNC_STAGES), .DATA_W(DATA_W)) u_link (
        .clk(clk), .rst_n(rst_n),
        .cs_i(spi_cs_i), .sclk_i(spi_sclk_i), .mosi_i(spi_mosi_i),
        .tx_byte_i(tx_byte), .cs_o(cs_s), .byte_stb_o(byte_stb),
        .byte_o(rx_byte), .load_stb_o(load_stb), .miso_o(spi_miso_o)
    );

    typedef struct packed {
        regfile_t          regs;
        logic [ADDR_W-1:0] addr;
        phase_t            phase;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (!cs_s) begin
            rf_d.phase = PH_CMD;
        end else if (byte_stb) begin
            unique case (rf_q.phase)
                PH_CMD: begin
                    rf_d.addr = rx_byte[ADDR_W-1:0];
                    if (!rx_byte[CMD_WR_BIT])     rf_d.phase = PH_SKIP;
                    else if (rx_byte[CMD_RD_BIT]) rf_d.phase = PH_READ;
                    else                          rf_d.phase = PH_WRITE;
                end
                PH_WRITE: begin
                    if (rf_q.addr == A_CTRL && (rx_byte & CLR_PATTERN) == CLR_PATTERN)
                        rf_d.regs = regfile_default();
                    else if (rf_q.addr == A_SEC)
                        rf_d.regs[A_SEC] = {1'b0, rx_byte[DATA_W-2:0]};
                    else
                        rf_d.regs[rf_q.addr] = rx_byte;
                    rf_d.addr = rf_q.addr + 1'b1;
                end
                default: ;
            endcase
        end else if (load_stb && rf_q.phase == PH_READ) begin
            rf_d.addr = rf_q.addr + 1'b1;
        end
        if (osc_fail_i) rf_d.regs[A_SEC][INVALID_BIT] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) rf_q <= '{regs: regfile_default(), addr: '0, phase: PH_CMD};
        else        rf_q <= rf_d;

    assign tx_byte = (rf_q.phase == PH_READ) ? rf_q.regs[rf_q.addr] : '0;
    assign run_o   = !rf_q.regs[A_CTRL][HALT_BIT];

    // R4: inside a data phase the pointer only leaves 0xF towards 0x0
    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_q.phase != PH_CMD && rf_q.addr == 4'hF) |=> (rf_q.addr == 4'hF || rf_q.addr == 4'h0));

    // R6: a halt write that is not the clear pattern stops the counters
    assert_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && cs_s && rf_q.phase == PH_WRITE && rf_q.addr == A_CTRL &&
         rx_byte[HALT_BIT] && (rx_byte & CLR_PATTERN) != CLR_PATTERN) |=> !run_o);

    // R7: the clear pattern restores seconds and the run state
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && cs_s && rf_q.phase == PH_WRITE && rf_q.addr == A_CTRL &&
         (rx_byte & CLR_PATTERN) == CLR_PATTERN) |=> (run_o && rf_q.regs[A_SEC] == 8'h80));

    // R8: a failure pulse always leaves the invalid flag set
    assert_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        osc_fail_i |=> rf_q.regs[A_SEC][INVALID_BIT]);
endmodule

// File: tb/sim_rtc_spi_regs.sv
module sim_rtc_spi_regs;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sclk = 1'b0, mosi = 1'b0, osc_fail = 1'b0;
    logic miso, run;
    int   n_tests = 0, n_fail = 0;
    logic [7:0] mdl [16];
    logic [7:0] rbuf [20];

    always #4 clk = ~clk;

    rtc_spi_regs #(.SYNC_STAGES(3)) u0 (
        .clk(clk), .rst_n(rst_n), .spi_cs_i(cs), .spi_sclk_i(sclk),
        .spi_mosi_i(mosi), .spi_miso_o(miso), .osc_fail_i(osc_fail), .run_o(run)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic void mdl_reset();
        for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
        mdl[2] = 8'h80;
    endfunction

    function automatic void mdl_write(input logic [3:0] a, input logic [7:0] v);
        if (a == 4'h0 && v[3] && v[4] && v[6]) mdl_reset();
        else if (a == 4'h2) mdl[2] = {1'b0, v[6:0]};
        else mdl[a] = v;
    endfunction

    task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int b = 0; b < nbits; b++) begin
            @(negedge clk) mosi = tx[7-b];
            repeat (HALF) @(negedge clk);
            rx[7-b] = miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic cs_on();
        @(negedge clk) cs = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_off();
        repeat (HALF) @(negedge clk);
        cs = 1'b0;
        repeat (2 * HALF) @(negedge clk);
    endtask

    // write n bytes from rbuf starting at address a
    task automatic wr_burst(input logic [3:0] a, input int n, input logic upd);
        logic [7:0] r;
        cs_on();
        xfer({4'b0001, a}, 8, r);
        for (int i = 0; i < n; i++) begin
            xfer(rbuf[i], 8, r);
            if (upd) mdl_write(a + 4'(i), rbuf[i]);
        end
        cs_off();
    endtask

    // read n bytes starting at address a and compare with the model
    task automatic rd_check(input string req, input logic [3:0] a, input int n);
        logic [7:0] r;
        cs_on();
        xfer({4'b1001, a}, 8, r);
        chk({req, " miso idle in command"}, r, 8'h00);
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, 8, r);
            chk(req, r, mdl[a + 4'(i)]);
        end
        cs_off();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] r;
        void'($urandom(32'd2024));
        mdl_reset();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state, R3 read, R4 wrap across all 16 addresses
        chk("R1 run after reset", {7'd0, run}, 8'h01);
        rd_check("R1 R3 R4 defaults", 4'h3, 16);

        // R2 single write, R3 read back
        rbuf[0] = 8'hA5;
        wr_burst(4'hD, 1, 1'b1);
        rd_check("R2 R3 single", 4'hD, 1);

        // R4 time burst, R8 written seconds bit7 cleared
        rbuf[0] = 8'hD9; rbuf[1] = 8'h59; rbuf[2] = 8'h23; rbuf[3] = 8'h31;
        rbuf[4] = 8'h06; rbuf[5] = 8'h12; rbuf[6] = 8'h99;
        wr_burst(4'h2, 7, 1'b1);
        rd_check("R4 R8 time burst", 4'h2, 7);

        // R4 wrap on write, R6 halt bit
        rbuf[0] = 8'h11; rbuf[1] = 8'h22; rbuf[2] = 8'h20;
        wr_burst(4'hE, 3, 1'b1);
        rd_check("R4 R6 write wrap", 4'hE, 3);
        chk("R6 halt lowers run", {7'd0, run}, 8'h00);
        rbuf[0] = 8'h00;
        wr_burst(4'h0, 1, 1'b1);
        chk("R6 zero restarts", {7'd0, run}, 8'h01);

        // R5 command without bit 4
        cs_on();
        xfer(8'h8D, 8, r);
        xfer(8'h3C, 8, r);
        chk("R5 miso quiet", r, 8'h00);
        xfer(8'h3C, 8, r);
        cs_off();
        cs_on();
        xfer(8'h0E, 8, r);
        xfer(8'h77, 8, r);
        cs_off();
        rd_check("R5 ignored", 4'hD, 2);

        // R8 failure flag set and cleared
        @(negedge clk) osc_fail = 1'b1;
        @(negedge clk) osc_fail = 1'b0;
        mdl[2][7] = 1'b1;
        rd_check("R8 flag set", 4'h2, 1);
        rbuf[0] = 8'h05;
        wr_burst(4'h2, 1, 1'b1);
        rd_check("R8 flag cleared", 4'h2, 1);

        // R9 select dropped mid data byte and mid command
        cs_on();
        xfer(8'h1D, 8, r);
        xfer(8'hFF, 4, r);
        cs = 1'b0;
        repeat (2 * HALF) @(negedge clk);
        cs_on();
        xfer(8'h1F, 5, r);
        cs = 1'b0;
        repeat (2 * HALF) @(negedge clk);
        rbuf[0] = 8'h3E;
        wr_burst(4'hF, 1, 1'b1);
        rd_check("R9 partial discarded", 4'hD, 3);

        // R7 clear pattern with halt set
        rbuf[0] = 8'h33; rbuf[1] = 8'h44;
        wr_burst(4'h8, 2, 1'b1);
        rbuf[0] = 8'h78;
        wr_burst(4'h0, 1, 1'b1);
        chk("R7 run after clear", {7'd0, run}, 8'h01);
        rd_check("R7 defaults", 4'h0, 16);

        // random bursts, model from the requirements
        for (int it = 0; it < 24; it++) begin
            logic [3:0] a;
            int n;
            a = 4'($urandom_range(0, 15));
            n = $urandom_range(1, 6);
            for (int i = 0; i < n; i++) rbuf[i] = 8'($urandom);
            wr_burst(a, n, 1'b1);
            chk("R6 run tracks halt", {7'd0, run}, {7'd0, ~mdl[0][5]});
            rd_check("R2 R3 R4 random", 4'($urandom_range(0, 15)), $urandom_range(1, 6));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule